// File: doc/BRIEF.md
# Indexed Configuration Port with Key Unlock

This block gives a host on an 8-bit I/O bus access to the configuration space of a legacy peripheral controller. It answers at two I/O addresses. The index port holds a register number, and the data port reads or writes the register that number selects. After reset the space is sealed. It opens only when a fixed four-byte key is written to the index port. A two-step exit command, an index write followed by a data write, seals it again.

When the space is open, the host sees a few global registers: the device bank selector, a read-only 16-bit identifier and a read-only revision nibble. When bank 7 is selected, the host also reaches the GPIO bank registers. These are a 16-bit I/O base address, one output-enable byte per group of eight lines, and a simple-I/O enable byte for each of the first few groups only. The contents of the GPIO registers are driven straight out of the block to the GPIO bank.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is sealed, and `gpio_oe`, `gpio_simple_en` and `gpio_base` are all zero.
- R2: The space opens only after the index port (0x2E) receives the bytes 0x87, 0x01, 0x55, 0x55 in that order. The same bytes written to the data port (0x2F) do nothing.
- R3: While sealed, a byte that does not match the key restarts matching. A mismatching 0x87 counts as the first key byte.
- R4: While sealed, every read of either port returns 0xFF, and data-port writes change no register.
- R5: While open, writing 0x02 to the index port and then 0x02 to the data port seals the space. Any other value written at index 0x02 leaves it open.
- R6: Index 0x07 is the read/write bank selector. GPIO registers are reachable only with bank 7 selected. With any other bank they read 0x00 and ignore writes.
- R7: Index 0x20 reads the identifier's high byte and index 0x21 its low byte. Writes to them are discarded.
- R8: Index 0x22 reads the revision in bits 3:0, with bits 7:4 zero. Writes to it are discarded.
- R9: With bank 7 selected, index 0x62 holds the high byte and index 0x63 the low byte of the GPIO base address. Both read back and drive `gpio_base`.
- R10: With bank 7 selected, index 0xC8+g holds the output-enable byte of group g. Bit b drives `gpio_oe[8*g+b]`.
- R11: With bank 7 selected, index 0xC0+g for g below NUM_SIMPLE (default 5) holds the simple-I/O byte of group g, which drives `gpio_simple_en[8*g+7:8*g]`. Index 0xC0+NUM_SIMPLE reads 0x00 and ignores writes.
- R12: `io_rdata` is registered. It shows the result one cycle after an `io_rd` strobe and reads 0xFF in every other cycle and for any other address. While open, an index-port read returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered read data |
| gpio_base | output | 16 | GPIO I/O base address |
| gpio_oe | output | 8*NUM_GROUPS | Output enable, one bit per line |
| gpio_simple_en | output | 8*NUM_SIMPLE | Simple-I/O enable for the switchable groups |

## Verification
A key matcher stuck in the wrong step shows at once: the next data-port read returns 0xFF where a register value was expected, or a real value where 0xFF was expected. A corrupted index or bank selector sends the next data access to the wrong register. That surfaces on the following read, or as an unexpected change on `gpio_oe`, `gpio_simple_en` or `gpio_base` one cycle after the write. An exit decode that is too loose seals the space early, and every read after it returns 0xFF.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
// Shared constants of the configuration port: key bytes and register indices.
// Assumes an 8-bit index space.
package sio_cfg_pkg;
    localparam int KEY_LEN = 4;

    localparam logic [7:0] IDX_EXIT     = 8'h02;
    localparam logic [7:0] EXIT_VALUE   = 8'h02;
    localparam logic [7:0] IDX_BANK     = 8'h07;
    localparam logic [7:0] IDX_ID_HI    = 8'h20;
    localparam logic [7:0] IDX_ID_LO    = 8'h21;
    localparam logic [7:0] IDX_REV      = 8'h22;
    localparam logic [7:0] IDX_BASE_HI  = 8'h62;
    localparam logic [7:0] IDX_BASE_LO  = 8'h63;
    localparam logic [7:0] IDX_SIMPLE0  = 8'hC0;
    localparam logic [7:0] IDX_OE0      = 8'hC8;
    localparam logic [7:0] READ_IDLE    = 8'hFF;

    // Key byte expected at a given step of the unlock sequence.
    function automatic logic [7:0] key_byte(input int step);
        case (step)
            0:       key_byte = 8'h87;
            1:       key_byte = 8'h01;
            default: key_byte = 8'h55;
        endcase
    endfunction
endpackage

// File: rtl/sio_key_match.sv
`timescale 1ns/1ps
// Unlock key matcher: follows the index-port byte stream while the space is
// sealed and opens it when the full key has arrived. Assumes the relock
// request is a single-cycle pulse from the register file.
module sio_key_match
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    input  logic       relock,
    output logic       unlocked
);
    localparam int CW = (KEY_LEN > 2) ? $clog2(KEY_LEN) : 1;

    logic [CW-1:0] step_q;
    logic          open_q;

    // Advance, restart or complete the key match; relock has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            open_q <= 1'b0;
        end else if (relock) begin
            step_q <= '0;
            open_q <= 1'b0;
        end else if (!open_q && idx_wr) begin
            if (wdata == key_byte(int'(step_q))) begin
                if (int'(step_q) == KEY_LEN - 1) begin
                    step_q <= '0;
                    open_q <= 1'b1;
                end else begin
                    step_q <= step_q + CW'(1);
                end
            end else if (wdata == key_byte(0)) begin
                step_q <= CW'(1);
            end else begin
                step_q <= '0;
            end
        end
    end

    assign unlocked = open_q;

    // R2: the space only opens right after the last key byte hits the index port
    assert_open_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_q) |-> $past(idx_wr && wdata == key_byte(KEY_LEN - 1)));
endmodule

// File: rtl/sio_cfg_regs.sv
`timescale 1ns/1ps
// Configuration register file: index register, bank selector, read-only
// identity, and the GPIO bank registers. Assumes 1 <= NUM_SIMPLE <= 8 and
// NUM_GROUPS <= 8 so the group ranges stay within their index windows.
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter int          NUM_GROUPS = 8,
    parameter int          NUM_SIMPLE = 5,
    parameter logic [7:0]  GPIO_BANK  = 8'h07,
    parameter logic [15:0] CHIP_ID    = 16'h5A31,
    parameter logic [3:0]  REVISION   = 4'h3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    unlocked,
    input  logic                    idx_wr,
    input  logic                    data_wr,
    input  logic [7:0]              wdata,
    output logic [7:0]              cur_index,
    output logic [7:0]              rd_value,
    output logic                    relock,
    output logic [15:0]             gpio_base,
    output logic [8*NUM_GROUPS-1:0] gpio_oe,
    output logic [8*NUM_SIMPLE-1:0] gpio_simple_en
);
    logic [7:0]  index_q;
    logic [7:0]  bank_q;
    logic [15:0] base_q;
    logic [7:0]  oe_q     [NUM_GROUPS];
    logic [7:0]  simple_q [NUM_SIMPLE];
    logic        wr_ok;
    logic        gpio_sel;

    assign wr_ok    = data_wr && unlocked;
    assign gpio_sel = (bank_q == GPIO_BANK);
    assign relock   = wr_ok && (index_q == IDX_EXIT) && (wdata == EXIT_VALUE);

    // Index register: loaded from the index port only while open.
    always_ff @(posedge clk) begin
        if (!rst_n)                   index_q <= '0;
        else if (idx_wr && unlocked)  index_q <= wdata;
    end

    // Bank selector: global register, writable while open.
    always_ff @(posedge clk) begin
        if (!rst_n)                              bank_q <= '0;
        else if (wr_ok && index_q == IDX_BANK)   bank_q <= wdata;
    end

    // GPIO base address, written a byte at a time within the GPIO bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_ok && gpio_sel) begin
            if (index_q == IDX_BASE_HI) base_q[15:8] <= wdata;
            if (index_q == IDX_BASE_LO) base_q[7:0]  <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_oe
        // Output-enable byte of one group.
        always_ff @(posedge clk) begin
            if (!rst_n)                                         oe_q[g] <= '0;
            else if (wr_ok && gpio_sel && index_q == IDX_OE0 + 8'(g)) oe_q[g] <= wdata;
        end
        assign gpio_oe[8*g +: 8] = oe_q[g];
    end

    for (genvar g = 0; g < NUM_SIMPLE; g++) begin : g_simple
        // Simple-I/O enable byte of one switchable group.
        always_ff @(posedge clk) begin
            if (!rst_n)                                             simple_q[g] <= '0;
            else if (wr_ok && gpio_sel && index_q == IDX_SIMPLE0 + 8'(g)) simple_q[g] <= wdata;
        end
        assign gpio_simple_en[8*g +: 8] = simple_q[g];
    end

    // Read multiplexer for the register the index points at.
    always_comb begin
        rd_value = 8'h00;
        case (index_q)
            IDX_BANK:  rd_value = bank_q;
            IDX_ID_HI: rd_value = CHIP_ID[15:8];
            IDX_ID_LO: rd_value = CHIP_ID[7:0];
            IDX_REV:   rd_value = {4'h0, REVISION};
            default: begin
                if (gpio_sel) begin
                    if (index_q == IDX_BASE_HI) rd_value = base_q[15:8];
                    if (index_q == IDX_BASE_LO) rd_value = base_q[7:0];
                    for (int g = 0; g < NUM_GROUPS; g++)
                        if (index_q == IDX_OE0 + 8'(g)) rd_value = oe_q[g];
                    for (int g = 0; g < NUM_SIMPLE; g++)
                        if (index_q == IDX_SIMPLE0 + 8'(g)) rd_value = simple_q[g];
                end
            end
        endcase
    end

    assign cur_index = index_q;
    assign gpio_base = base_q;

    // R4: nothing reaches the output enables while sealed
    assert_sealed_oe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(gpio_oe));
    // R6: a non-GPIO bank keeps the GPIO registers untouched
    assert_bank_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_sel |=> ($stable(gpio_oe) && $stable(gpio_simple_en) && $stable(gpio_base)));
endmodule

// File: rtl/sio_cfg_port.sv
`timescale 1ns/1ps
// Top of the indexed configuration port: decodes the two I/O addresses,
// joins the key matcher and the register file, and registers read data.
// Assumes single-cycle read and write strobes.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] INDEX_PORT = 16'h002E,
    parameter logic [15:0] DATA_PORT  = 16'h002F,
    parameter int          NUM_GROUPS = 8,
    parameter int          NUM_SIMPLE = 5,
    parameter logic [7:0]  GPIO_BANK  = 8'h07,
    parameter logic [15:0] CHIP_ID    = 16'h5A31,
    parameter logic [3:0]  REVISION   = 4'h3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    io_wr,
    input  logic                    io_rd,
    input  logic [15:0]             io_addr,
    input  logic [7:0]              io_wdata,
    output logic [7:0]              io_rdata,
    output logic [15:0]             gpio_base,
    output logic [8*NUM_GROUPS-1:0] gpio_oe,
    output logic [8*NUM_SIMPLE-1:0] gpio_simple_en
);
    logic       hit_index, hit_data;
    logic       unlocked, relock;
    logic [7:0] cur_index, rd_value;
    logic [7:0] rdata_q;

    assign hit_index = (io_addr == INDEX_PORT);
    assign hit_data  = (io_addr == DATA_PORT);

    sio_key_match u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && hit_index),
        .wdata    (io_wdata),
        .relock   (relock),
        .unlocked (unlocked)
    );

    sio_cfg_regs #(
        .NUM_GROUPS (NUM_GROUPS),
        .NUM_SIMPLE (NUM_SIMPLE),
        .GPIO_BANK  (GPIO_BANK),
        .CHIP_ID    (CHIP_ID),
        .REVISION   (REVISION)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .unlocked       (unlocked),
        .idx_wr         (io_wr && hit_index),
        .data_wr        (io_wr && hit_data),
        .wdata          (io_wdata),
        .cur_index      (cur_index),
        .rd_value       (rd_value),
        .relock         (relock),
        .gpio_base      (gpio_base),
        .gpio_oe        (gpio_oe),
        .gpio_simple_en (gpio_simple_en)
    );

    // Registered read data; idle value whenever no valid open-space read.
    always_ff @(posedge clk) begin
        if (!rst_n)                               rdata_q <= READ_IDLE;
        else if (io_rd && unlocked && hit_index)  rdata_q <= cur_index;
        else if (io_rd && unlocked && hit_data)   rdata_q <= rd_value;
        else                                      rdata_q <= READ_IDLE;
    end

    assign io_rdata = rdata_q;

    // R5: an accepted exit command seals the space on the next cycle
    assert_exit_seals_R5: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> !unlocked);
    // R12: with no read strobe the data bus returns the idle value
    assert_idle_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> io_rdata == READ_IDLE);
    // R4: sealed reads always return the idle value
    assert_sealed_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> io_rdata == READ_IDLE);
endmodule

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module test_sio_cfg_port;
    localparam logic [15:0] IDXP = 16'h002E;
    localparam logic [15:0] DATP = 16'h002F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [15:0] gpio_base;
    logic [63:0] gpio_oe;
    logic [39:0] gpio_simple_en;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    sio_cfg_port i_sio_cfg_port (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .gpio_base(gpio_base), .gpio_oe(gpio_oe), .gpio_simple_en(gpio_simple_en)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
        io_rd = 1'b1; io_addr = a;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        wr(IDXP, idx); wr(DATP, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx, input logic [7:0] exp, input string req);
        wr(IDXP, idx); rd(DATP, exp, req);
    endtask

    task automatic send_key();
        wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    endtask

    // Monitor: note a read strobe at the edge, compare the result half a cycle later.
    always @(posedge clk) rd_seen <= io_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: actual %h expected none", io_rdata);
            end else begin
                check(tag_q.pop_front(), {56'h0, io_rdata}, {56'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", gpio_oe, 64'h0);
        check("R1 simple", {24'h0, gpio_simple_en}, 64'h0);
        check("R1 base", {48'h0, gpio_base}, 64'h0);
        rd(DATP, 8'hFF, "R1 sealed after reset");
        // R4 sealed: data writes ignored, reads idle
        wr(DATP, 8'hC8); wr(DATP, 8'hFF);
        rd(IDXP, 8'hFF, "R4 sealed index read");
        check("R4 oe unchanged", gpio_oe, 64'h0);
        // R2 key on data port does nothing
        wr(DATP, 8'h87); wr(DATP, 8'h01); wr(DATP, 8'h55); wr(DATP, 8'h55);
        rd(DATP, 8'hFF, "R2 key on data port");
        // R3 mismatch restarts
        wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'hAA);
        wr(IDXP, 8'h55);
        rd(DATP, 8'hFF, "R3 wrong byte keeps sealed");
        wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h87);
        wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
        // R3 restart with 0x87 then R2 open
        wr(IDXP, 8'h20);
        rd(IDXP, 8'h20, "R3 R2 open after restart, index readback");
        // R7 identifier, read-only
        rd(DATP, 8'h5A, "R7 id high");
        reg_rd(8'h21, 8'h31, "R7 id low");
        reg_wr(8'h20, 8'hAB);
        reg_rd(8'h20, 8'h5A, "R7 id write discarded");
        // R8 revision
        reg_wr(8'h22, 8'hFF);
        reg_rd(8'h22, 8'h03, "R8 revision");
        // R6 other bank gates GPIO registers
        reg_wr(8'h07, 8'h03);
        reg_rd(8'h07, 8'h03, "R6 bank readback");
        reg_wr(8'hC8, 8'hFF);
        check("R6 oe ignored", gpio_oe, 64'h0);
        reg_rd(8'hC8, 8'h00, "R6 gated read");
        reg_wr(8'h07, 8'h07);
        // R9 base
        reg_wr(8'h62, 8'h12); reg_wr(8'h63, 8'h34);
        check("R9 base", {48'h0, gpio_base}, 64'h1234);
        reg_rd(8'h62, 8'h12, "R9 base high");
        reg_rd(8'h63, 8'h34, "R9 base low");
        // R10 output enables
        reg_wr(8'hC8, 8'hA5); reg_wr(8'hCF, 8'h3C);
        check("R10 oe", gpio_oe, 64'h3C00_0000_0000_00A5);
        reg_rd(8'hCF, 8'h3C, "R10 oe readback");
        // R11 simple-I/O range
        reg_wr(8'hC4, 8'h5A); reg_wr(8'hC5, 8'hFF);
        check("R11 simple", {24'h0, gpio_simple_en}, {24'h0, 40'h5A_0000_0000});
        reg_rd(8'hC5, 8'h00, "R11 beyond range");
        reg_rd(8'hC4, 8'h5A, "R11 readback");
        // R12 other address reads idle
        rd(16'h0080, 8'hFF, "R12 foreign address");
        // R5 exit
        reg_wr(8'h02, 8'h03);
        rd(IDXP, 8'h02, "R5 wrong exit value keeps open");
        wr(DATP, 8'h02);
        rd(DATP, 8'hFF, "R5 sealed after exit");
        wr(IDXP, 8'hC8); wr(DATP, 8'h00);
        check("R5 R4 oe kept while sealed", gpio_oe, 64'h3C00_0000_0000_00A5);
        send_key();
        reg_rd(8'hC8, 8'hA5, "R2 reopen retains state");
        repeat (3) @(negedge clk);
        check("scoreboard drained", {32'h0, exp_q.size()}, 64'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule